// File: doc/BRIEF.md
# Read-after-write hazard unit for a five-stage integer pipeline

This block resolves read-after-write hazards in an in-order pipeline whose stages are fetch, decode with register read, execute, memory access and writeback. Registers are read only in decode and written only in writeback. Every instruction takes the same five stages, so only true dependences (a read that follows a write) can cause a hazard.

For each ALU operand the unit picks one of three sources. The first is the register file value. The second is the result held in the execute-to-memory latch. The third is the value held in the memory-to-writeback latch. When both latches hold a write to the register being read, the younger one wins. A load that is followed at once by an instruction reading its destination cannot be covered by forwarding. In that case the unit holds the program counter and the fetch/decode latch for one cycle and turns the instruction entering execute into a bubble. The loaded value then reaches the consumer from the writeback latch.

A parameter chooses when the operand selects are formed. With `EARLY_SEL = 0` they are formed in execute from the execute-stage source numbers. With `EARLY_SEL = 1` they are formed in decode and registered along with the decode-to-execute transfer. The register file, the ALU and the memories lie outside the block. The register file is expected to return a value written in the same cycle.

Top module: `raw_hazard_unit`

## Requirements
- R1: The two-bit operand selects use this encoding: 2'b00 means register file, 2'b01 means the memory-to-writeback latch, 2'b10 means the execute-to-memory latch, and 2'b11 never appears. `opa_sel` serves the first source of the instruction in execute, and `opb_sel` serves the second source.
- R2: A select is 2'b10 when the execute-to-memory latch has its write enable set, is not a load, and has a destination equal to the nonzero source number.
- R3: When R2 does not apply, a select is 2'b01 when the memory-to-writeback latch has its write enable set and a destination equal to the nonzero source number. When both latches match, the execute-to-memory latch has priority.
- R4: Register 0 is never a forwarding source and never causes a stall. A source or destination of 0 gives select 2'b00 and no hold. Instructions that use fewer than two sources present 0 for the unused ones.
- R5: `pc_hold`, `fd_hold` and `ie_bubble` are all high in the same cycle exactly when the decode-to-execute latch holds a load with write enable set and a nonzero destination equal to either decode source. Otherwise all three are low.
- R6: A load two or more slots ahead of a dependent instruction (one held in the execute-to-memory latch or later) causes no hold.
- R7: With `EARLY_SEL = 1` the selects equal those of R1–R3, evaluated on the execute-stage sources, in every cycle of a pipeline that obeys the holds and bubbles of R5.
- R8: With `EARLY_SEL = 1` both selects are 2'b00 while `rst` is high and in the first cycle after it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src1 | input | REG_W | First source register of the instruction in decode |
| dec_src2 | input | REG_W | Second source register of the instruction in decode |
| exe_src1 | input | REG_W | First source register of the instruction in execute |
| exe_src2 | input | REG_W | Second source register of the instruction in execute |
| ie_dst | input | REG_W | Destination held in the decode-to-execute latch |
| ie_wen | input | 1 | Write enable held in the decode-to-execute latch |
| ie_load | input | 1 | Load flag held in the decode-to-execute latch |
| em_dst | input | REG_W | Destination held in the execute-to-memory latch |
| em_wen | input | 1 | Write enable held in the execute-to-memory latch |
| em_load | input | 1 | Load flag held in the execute-to-memory latch |
| mw_dst | input | REG_W | Destination held in the memory-to-writeback latch |
| mw_wen | input | 1 | Write enable held in the memory-to-writeback latch |
| opa_sel | output | 2 | Source select for ALU operand A |
| opb_sel | output | 2 | Source select for ALU operand B |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| fd_hold | output | 1 | Keep the fetch/decode latch unchanged this cycle |
| ie_bubble | output | 1 | Load a no-op into the decode-to-execute latch |

## Verification
The bench builds two copies of the unit with `REG_W = 3`, one with `EARLY_SEL = 0` and one with `EARLY_SEL = 1`, and drives both from the same stub pipeline. That pipeline obeys the hold outputs. With only eight register numbers, random source and destination fields collide very often. Thousands of cycles therefore cover every hazard pattern many times: a match on one latch or on both, a match on register 0, load-use stalls, and loads two slots ahead. Running both copies side by side shows that the registered-select variant and the late-compare variant agree cycle for cycle.

// File: rtl/rhu_pkg.sv
package rhu_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_WB  = 2'b01,
        SRC_MEM = 2'b10
    } opnd_src_e;

    // Younger producer wins over the older one.
    function automatic opnd_src_e pick_src(input logic near_hit, input logic far_hit);
        if (near_hit)
            return SRC_MEM;
        else if (far_hit)
            return SRC_WB;
        return SRC_RF;
    endfunction

endpackage

// File: rtl/rhu_operand_sel.sv
module rhu_operand_sel #(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0]    src,
    input  logic [REG_W-1:0]    near_dst,
    input  logic                near_wen,
    input  logic                near_load,
    input  logic [REG_W-1:0]    far_dst,
    input  logic                far_wen,
    output rhu_pkg::opnd_src_e  sel
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic src_live;
    logic near_hit;
    logic far_hit;

    always_comb begin
        src_live = (src != ZERO_REG);
        // A load in the near slot has no data yet; the interlock keeps that case away.
        near_hit = src_live && near_wen && !near_load && (near_dst == src);
        far_hit  = src_live && far_wen && (far_dst == src);
        sel      = rhu_pkg::pick_src(near_hit, far_hit);
    end

endmodule

// File: rtl/rhu_load_detect.sv
module rhu_load_detect #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned N_SRC = 2
) (
    input  logic [N_SRC-1:0][REG_W-1:0] srcs,
    input  logic [REG_W-1:0]            ld_dst,
    input  logic                        ld_wen,
    input  logic                        ld_flag,
    output logic                        use_stall
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [N_SRC-1:0] hit;
    logic             producer_live;

    assign producer_live = ld_flag && ld_wen && (ld_dst != ZERO_REG);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = producer_live && (srcs[i] == ld_dst);
    end

    assign use_stall = |hit;

endmodule

// File: rtl/raw_hazard_unit.sv
module raw_hazard_unit #(
    parameter int unsigned REG_W     = 5,
    parameter bit          EARLY_SEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] dec_src1,
    input  logic [REG_W-1:0] dec_src2,
    input  logic [REG_W-1:0] exe_src1,
    input  logic [REG_W-1:0] exe_src2,
    input  logic [REG_W-1:0] ie_dst,
    input  logic             ie_wen,
    input  logic             ie_load,
    input  logic [REG_W-1:0] em_dst,
    input  logic             em_wen,
    input  logic             em_load,
    input  logic [REG_W-1:0] mw_dst,
    input  logic             mw_wen,
    output logic [1:0]       opa_sel,
    output logic [1:0]       opb_sel,
    output logic             pc_hold,
    output logic             fd_hold,
    output logic             ie_bubble
);
    import rhu_pkg::*;

    localparam int unsigned N_OPND = 2;

    logic [N_OPND-1:0][REG_W-1:0] dec_src_a;
    logic [N_OPND-1:0][REG_W-1:0] exe_src_a;
    opnd_src_e                    sel_a [N_OPND];
    logic                         load_use;

    assign dec_src_a = {dec_src2, dec_src1};
    assign exe_src_a = {exe_src2, exe_src1};

    rhu_load_detect #(
        .REG_W (REG_W),
        .N_SRC (N_OPND)
    ) u_load_detect (
        .srcs      (dec_src_a),
        .ld_dst    (ie_dst),
        .ld_wen    (ie_wen),
        .ld_flag   (ie_load),
        .use_stall (load_use)
    );

    if (EARLY_SEL) begin : g_early
        // Decode compares against the slots its instruction will meet next cycle.
        opnd_src_e sel_nxt [N_OPND];
        opnd_src_e sel_q   [N_OPND];
        logic      unused_late;

        assign unused_late = ^{exe_src_a, em_load, mw_dst, mw_wen};

        for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
            rhu_operand_sel #(.REG_W(REG_W)) u_sel (
                .src       (dec_src_a[i]),
                .near_dst  (ie_dst),
                .near_wen  (ie_wen),
                .near_load (ie_load),
                .far_dst   (em_dst),
                .far_wen   (em_wen),
                .sel       (sel_nxt[i])
            );

            always_ff @(posedge clk) begin
                if (rst || load_use)
                    sel_q[i] <= SRC_RF;
                else
                    sel_q[i] <= sel_nxt[i];
            end

            assign sel_a[i] = sel_q[i];
        end
    end else begin : g_late
        logic unused_clk;

        assign unused_clk = ^{clk, rst};

        for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
            rhu_operand_sel #(.REG_W(REG_W)) u_sel (
                .src       (exe_src_a[i]),
                .near_dst  (em_dst),
                .near_wen  (em_wen),
                .near_load (em_load),
                .far_dst   (mw_dst),
                .far_wen   (mw_wen),
                .sel       (sel_a[i])
            );
        end
    end

    assign opa_sel   = sel_a[0];
    assign opb_sel   = sel_a[1];
    assign pc_hold   = load_use;
    assign fd_hold   = load_use;
    assign ie_bubble = load_use;

endmodule

// File: rtl/rhu_checker.sv
module rhu_checker #(
    parameter int unsigned REG_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] exe_src1,
    input logic [REG_W-1:0] exe_src2,
    input logic [REG_W-1:0] em_dst,
    input logic             em_wen,
    input logic             em_load,
    input logic [REG_W-1:0] mw_dst,
    input logic             mw_wen,
    input logic [1:0]       opa_sel,
    input logic [1:0]       opb_sel,
    input logic             pc_hold
);
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (opa_sel != 2'b11) && (opb_sel != 2'b11)); // R1

    AST_MEM_FWD_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (opa_sel == 2'b10) |-> (em_wen && !em_load && em_dst == exe_src1)); // R2

    AST_NO_LOAD_MEM_FWD: assert property (@(posedge clk) disable iff (rst)
        em_load |-> (opa_sel != 2'b10 && opb_sel != 2'b10)); // R2

    AST_WB_FWD_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (opb_sel == 2'b01) |-> (mw_wen && mw_dst == exe_src2 && mw_dst != '0)); // R3

    AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        (exe_src1 == '0) |-> (opa_sel == 2'b00)); // R4

    AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        pc_hold |=> !pc_hold); // R5

endmodule

bind raw_hazard_unit rhu_checker #(.REG_W(REG_W)) u_rhu_checker (
    .clk      (clk),
    .rst      (rst),
    .exe_src1 (exe_src1),
    .exe_src2 (exe_src2),
    .em_dst   (em_dst),
    .em_wen   (em_wen),
    .em_load  (em_load),
    .mw_dst   (mw_dst),
    .mw_wen   (mw_wen),
    .opa_sel  (opa_sel),
    .opb_sel  (opb_sel),
    .pc_hold  (pc_hold)
);

// File: tb/raw_hazard_unit_bench.sv
module raw_hazard_unit_bench;
    localparam int RW     = 3;
    localparam int N_CYC  = 4000;
    localparam int CLK_NS = 10;

    typedef struct packed {
        logic [RW-1:0] s1;
        logic [RW-1:0] s2;
        logic [RW-1:0] d;
        logic          we;
        logic          ld;
    } ins_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    ins_t id_i = '0, ie_i = '0, em_i = '0, mw_i = '0;

    logic [1:0] a0, b0, a1, b1;
    logic       ph0, fh0, ib0, ph1, fh1, ib1;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_NS/2) clk = ~clk;

    raw_hazard_unit #(.REG_W(RW), .EARLY_SEL(1'b0)) u_raw_hazard_unit (
        .clk(clk), .rst(rst),
        .dec_src1(id_i.s1), .dec_src2(id_i.s2),
        .exe_src1(ie_i.s1), .exe_src2(ie_i.s2),
        .ie_dst(ie_i.d), .ie_wen(ie_i.we), .ie_load(ie_i.ld),
        .em_dst(em_i.d), .em_wen(em_i.we), .em_load(em_i.ld),
        .mw_dst(mw_i.d), .mw_wen(mw_i.we),
        .opa_sel(a0), .opb_sel(b0),
        .pc_hold(ph0), .fd_hold(fh0), .ie_bubble(ib0)
    );

    raw_hazard_unit #(.REG_W(RW), .EARLY_SEL(1'b1)) u_raw_hazard_unit_reg (
        .clk(clk), .rst(rst),
        .dec_src1(id_i.s1), .dec_src2(id_i.s2),
        .exe_src1(ie_i.s1), .exe_src2(ie_i.s2),
        .ie_dst(ie_i.d), .ie_wen(ie_i.we), .ie_load(ie_i.ld),
        .em_dst(em_i.d), .em_wen(em_i.we), .em_load(em_i.ld),
        .mw_dst(mw_i.d), .mw_wen(mw_i.we),
        .opa_sel(a1), .opb_sel(b1),
        .pc_hold(ph1), .fd_hold(fh1), .ie_bubble(ib1)
    );

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    function automatic logic [1:0] exp_sel(input logic [RW-1:0] s, input ins_t em, input ins_t mw);
        if (s == 0) return 2'b00;
        if (em.we && !em.ld && em.d == s) return 2'b10;
        if (mw.we && mw.d == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_stall(input ins_t id, input ins_t ie);
        return ie.ld && ie.we && ie.d != 0 && (ie.d == id.s1 || ie.d == id.s2);
    endfunction

    function automatic string sel_tag(input logic [RW-1:0] s, input logic [1:0] e);
        if (s == 0) return "R4";
        if (e == 2'b10) return "R2";
        if (e == 2'b01) return "R3";
        return "R1";
    endfunction

    logic [15:0] lcg = 16'h1d3b;

    function automatic ins_t make_ins(input logic [15:0] x);
        ins_t n;
        n.s1 = x[15:13];
        n.s2 = x[12:10];
        n.d  = x[9:7];
        n.we = (x[6:5] != 2'b00);
        n.ld = n.we && (x[4:3] == 2'b00);
        return n;
    endfunction

    initial begin : watchdog
        #(CLK_NS * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin : stim
        int cnt_stall, cnt_pri, cnt_late;
        logic st;
        logic [1:0] ea, eb;
        string ta, tb, tst;
        cnt_stall = 0; cnt_pri = 0; cnt_late = 0;

        // Reset with a forwardable pattern visible to decode: registered selects must stay 00.
        id_i = '{s1: 3'd3, s2: 3'd0, d: 3'd1, we: 1'b1, ld: 1'b0};
        ie_i = '{s1: 3'd0, s2: 3'd0, d: 3'd3, we: 1'b1, ld: 1'b0};
        repeat (3) @(posedge clk);
        #5;
        check("R8 opa during reset", a1, 0);
        check("R8 opb during reset", b1, 0);
        check("R4 late opa zero source", a0, 0);
        check("R5 no hold without load", ph0, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        id_i = '0; ie_i = '0; em_i = '0; mw_i = '0;
        #4;
        check("R8 opa first cycle", a1, 0);
        check("R8 opb first cycle", b1, 0);

        for (int c = 0; c < N_CYC; c++) begin
            st = exp_stall(id_i, ie_i);
            @(posedge clk);
            #1;
            mw_i = em_i;
            em_i = ie_i;
            if (st) begin
                ie_i = '0;
            end else begin
                ie_i = id_i;
                lcg  = lcg * 16'd25173 + 16'd13849;
                id_i = make_ins(lcg);
            end
            #4;
            ea = exp_sel(ie_i.s1, em_i, mw_i);
            eb = exp_sel(ie_i.s2, em_i, mw_i);
            ta = sel_tag(ie_i.s1, ea);
            tb = sel_tag(ie_i.s2, eb);
            check({ta, " late opa"}, a0, ea);
            check({tb, " late opb"}, b0, eb);
            check({"R7 early opa ", ta}, a1, ea);
            check({"R7 early opb ", tb}, b1, eb);
            st = exp_stall(id_i, ie_i);
            tst = (em_i.ld && em_i.we && em_i.d != 0 &&
                   (em_i.d == id_i.s1 || em_i.d == id_i.s2)) ? "R6" : "R5";
            check({tst, " pc_hold"}, ph0, st);
            check({tst, " fd_hold"}, fh0, st);
            check({tst, " ie_bubble"}, ib0, st);
            check({tst, " early pc_hold"}, ph1, st);
            check({tst, " early ie_bubble"}, ib1, st);
            if (st) cnt_stall++;
            if (tst == "R6" && !st) cnt_late++;
            if (ie_i.s1 != 0 && em_i.we && !em_i.ld && em_i.d == ie_i.s1 &&
                mw_i.we && mw_i.d == ie_i.s1) cnt_pri++;
        end

        check("R5 load-use stalls seen", int'(cnt_stall > 0), 1);
        check("R6 loads two ahead seen", int'(cnt_late > 0), 1);
        check("R3 both-latch matches seen", int'(cnt_pri > 0), 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule